// File: doc/BRIEF.md
# Memory Controller Reset Steering with Refresh Retention

This block sits at the reset boundary of an external memory controller that serves both static memories and SDRAM. It takes a power-on reset (also raised on brown-out) and a warm reset (raised by the external reset pin or by the watchdog). It synchronises both into the controller clock and splits them into two domains. The core domain is cleared by any reset. The retained domain holds the SDRAM refresh interval register, the refresh countdown and the refresh request pulse.

A retention bit selects how a warm reset is handled. When the bit is clear, a warm reset clears both domains. When the bit is set, a warm reset clears only the core domain, and refresh requests keep coming at the programmed interval while the rest of the controller restarts. Only a power-on or brown-out reset clears the retention bit.

The block also registers the memory interface pins. While a reset is active, each pin group is forced to its safe level, and the same holds for the SDRAM strobes during self-refresh. Otherwise the pins pass through the values from the access sequencer. That sequencer and the register decoding sit outside this block.

Top module: `mc_reset_steer`

## Requirements
- R1: Raising `por_in` or `warm_in` drives the matching reset outputs high at once, without waiting for a clock edge. After the input falls, the reset is released on the second rising clock edge.
- R2: With the retention bit at 0, a warm reset raises both `rst_core` and `rst_keep`. No refresh request is issued while it lasts. The interval returns to `IVL_DEF`, so the first request after release appears `IVL_DEF`+3 edges after `warm_in` falls.
- R3: With the retention bit at 1, a warm reset raises `rst_core` but leaves `rst_keep` low. Refresh requests continue through the reset and after it at the programmed spacing.
- R4: A power-on or brown-out reset clears both domains and the retention bit, even when the retention bit is 1.
- R5: The retention bit changes only on a clock edge with `keep_we` high; otherwise `keep_din` is ignored. A warm reset never clears it. `keep_q` shows its value.
- R6: Outside reset and self-refresh, `refresh_req` is a one-cycle pulse with exactly interval+1 cycles between pulses. The interval is loaded through `ivl_we`/`ivl_din` and takes effect at the next reload.
- R7: One edge after `rst_core` is high, the static pins are at their safe levels: `mem_addr` and `mem_dout` are 0, and `mem_oe_n`, `mem_we_n`, `mem_bls_n` and `mem_cs_n` are all ones.
- R8: One edge after `rst_keep` or `self_refresh` is high, `mem_dycs_n` is all ones and `mem_ras_n`/`mem_cas_n` are 1.
- R9: While `self_refresh` is high, no `refresh_req` pulse is issued.
- R10: Outside the safe conditions, each pin takes its `fn_*` input one edge later. When `fn_sdram_sel` is 1, `mem_addr` bits 23 to 15 are 0 and bits 14 to 0 follow `fn_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_in | input | 1 | Power-on / brown-out reset, active high |
| warm_in | input | 1 | Warm reset from pin or watchdog, active high |
| keep_we | input | 1 | Write strobe for the retention bit |
| keep_din | input | 1 | New retention bit value |
| ivl_we | input | 1 | Write strobe for the refresh interval |
| ivl_din | input | IVL_W (8) | New refresh interval |
| self_refresh | input | 1 | SDRAM is in self-refresh |
| fn_sdram_sel | input | 1 | Current access targets SDRAM (15-bit address) |
| fn_addr | input | 24 | Address from the sequencer |
| fn_dout | input | 32 | Write data from the sequencer |
| fn_oe_n | input | 1 | Output enable from the sequencer |
| fn_we_n | input | 1 | Write enable from the sequencer |
| fn_bls_n | input | 4 | Byte lane selects from the sequencer |
| fn_cs_n | input | 4 | Static chip selects from the sequencer |
| fn_dycs_n | input | 4 | SDRAM chip selects from the sequencer |
| fn_ras_n | input | 1 | Row strobe from the sequencer |
| fn_cas_n | input | 1 | Column strobe from the sequencer |
| rst_core | output | 1 | Core domain reset, active high |
| rst_keep | output | 1 | Retained domain reset, active high |
| keep_q | output | 1 | Current retention bit |
| refresh_req | output | 1 | One-cycle refresh request |
| mem_addr | output | 24 | Address pins |
| mem_dout | output | 32 | Data output pins |
| mem_oe_n | output | 1 | Output enable pin |
| mem_we_n | output | 1 | Write enable pin |
| mem_bls_n | output | 4 | Byte lane select pins |
| mem_cs_n | output | 4 | Static chip select pins |
| mem_dycs_n | output | 4 | SDRAM chip select pins |
| mem_ras_n | output | 1 | Row address strobe pin |
| mem_cas_n | output | 1 | Column address strobe pin |

## Verification
The reset outputs rise in the same time step as a reset input and are checked one time unit later, before any clock edge. Their release is checked at the falling edge after the first and after the second rising edge that follow the input's fall. Pin values and refresh pulses are registered, so every input is driven on a falling edge and the result is sampled on the next falling edge. The first refresh request after a clearing reset is expected at the falling edge that follows rising edge `IVL_DEF`+3 counted from the release: two edges of synchroniser, then the countdown, then the pulse register. Spacing between requests is counted in falling edges and must equal the interval plus one, including across a retained warm reset.

// File: rtl/mcrs_pkg.sv
package mcrs_pkg;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;
  localparam int NCS       = 4;
  localparam int SD_ADDR_W = 15;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dout;
    logic              oe_n;
    logic              we_n;
    logic [LANES-1:0]  bls_n;
    logic [NCS-1:0]    cs_n;
    logic [NCS-1:0]    dycs_n;
    logic              ras_n;
    logic              cas_n;
  } pin_bundle_t;
endpackage

// File: rtl/mcrs_sync.sv
module mcrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] shreg;

  // asserted asynchronously, released after STAGES rising edges
  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) shreg <= '1;
    else        shreg <= {shreg[STAGES-2:0], 1'b0};
  end

  assign rst_out = shreg[STAGES-1];
endmodule

// File: rtl/mcrs_refresh.sv
module mcrs_refresh #(
  parameter int IVL_W   = 8,
  parameter int IVL_DEF = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             self_refresh,
  input  logic             ivl_we,
  input  logic [IVL_W-1:0] ivl_din,
  output logic             req
);
  localparam logic [IVL_W-1:0] DEF_V = IVL_W'(IVL_DEF);

  logic [IVL_W-1:0] ivl;
  logic [IVL_W-1:0] cnt;
  logic             hit;

  assign hit = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)         ivl <= DEF_V;
    else if (ivl_we) ivl <= ivl_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= DEF_V;
      req <= 1'b0;
    end else begin
      cnt <= hit ? ivl : cnt - 1'b1;
      req <= hit & ~self_refresh;
    end
  end

  // R6: a pulse followed by a nonzero reload lasts one cycle
  assert_one_cycle_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (req && cnt != '0) |=> !req);

  // R9: no request follows a cycle in self-refresh
  assert_quiet_selfref_R9: assert property (@(posedge clk) disable iff (rst)
    self_refresh |=> !req);
endmodule

// File: rtl/mcrs_pins.sv
module mcrs_pins
  import mcrs_pkg::*;
(
  input  logic        clk,
  input  logic        st_safe,
  input  logic        sd_safe,
  input  logic        sd_addr_only,
  input  pin_bundle_t fn,
  output pin_bundle_t pins
);
  pin_bundle_t nxt;

  always_comb begin
    nxt = fn;
    if (sd_addr_only)
      nxt.addr = {{(ADDR_W-SD_ADDR_W){1'b0}}, fn.addr[SD_ADDR_W-1:0]};
    if (st_safe) begin
      nxt.addr  = '0;
      nxt.dout  = '0;
      nxt.oe_n  = 1'b1;
      nxt.we_n  = 1'b1;
      nxt.bls_n = '1;
      nxt.cs_n  = '1;
    end
    if (sd_safe) begin
      nxt.dycs_n = '1;
      nxt.ras_n  = 1'b1;
      nxt.cas_n  = 1'b1;
    end
  end

  always_ff @(posedge clk) pins <= nxt;

  // R7: static pins reach safe levels one edge after the core reset
  assert_static_safe_R7: assert property (@(posedge clk)
    st_safe |=> (pins.addr == '0 && pins.dout == '0 && pins.oe_n && pins.we_n
                 && (&pins.bls_n) && (&pins.cs_n)));

  // R8: SDRAM strobes idle one edge after retained reset or self-refresh
  assert_sdram_idle_R8: assert property (@(posedge clk)
    sd_safe |=> ((&pins.dycs_n) && pins.ras_n && pins.cas_n));
endmodule

// File: rtl/mc_reset_steer.sv
module mc_reset_steer
  import mcrs_pkg::*;
#(
  parameter int IVL_W       = 8,
  parameter int IVL_DEF     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_in,
  input  logic              warm_in,
  input  logic              keep_we,
  input  logic              keep_din,
  input  logic              ivl_we,
  input  logic [IVL_W-1:0]  ivl_din,
  input  logic              self_refresh,
  input  logic              fn_sdram_sel,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_dout,
  input  logic              fn_oe_n,
  input  logic              fn_we_n,
  input  logic [LANES-1:0]  fn_bls_n,
  input  logic [NCS-1:0]    fn_cs_n,
  input  logic [NCS-1:0]    fn_dycs_n,
  input  logic              fn_ras_n,
  input  logic              fn_cas_n,
  output logic              rst_core,
  output logic              rst_keep,
  output logic              keep_q,
  output logic              refresh_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bls_n,
  output logic [NCS-1:0]    mem_cs_n,
  output logic [NCS-1:0]    mem_dycs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n
);
  logic        por_s;
  logic        warm_s;
  logic        keep_bit;
  pin_bundle_t fn_b;
  pin_bundle_t pin_b;

  mcrs_sync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk(clk), .rst_in(por_in), .rst_out(por_s));
  mcrs_sync #(.STAGES(SYNC_STAGES)) u_sync_warm (
    .clk(clk), .rst_in(warm_in), .rst_out(warm_s));

  // retention bit lives in the power-on-only domain
  always_ff @(posedge clk) begin
    if (por_s)        keep_bit <= 1'b0;
    else if (keep_we) keep_bit <= keep_din;
  end

  assign rst_core = por_s | warm_s;
  assign rst_keep = por_s | (warm_s & ~keep_bit);
  assign keep_q   = keep_bit;

  mcrs_refresh #(.IVL_W(IVL_W), .IVL_DEF(IVL_DEF)) u_refresh (
    .clk(clk), .rst(rst_keep), .self_refresh(self_refresh),
    .ivl_we(ivl_we), .ivl_din(ivl_din), .req(refresh_req));

  assign fn_b = '{addr: fn_addr, dout: fn_dout, oe_n: fn_oe_n, we_n: fn_we_n,
                  bls_n: fn_bls_n, cs_n: fn_cs_n, dycs_n: fn_dycs_n,
                  ras_n: fn_ras_n, cas_n: fn_cas_n};

  mcrs_pins u_pins (
    .clk(clk), .st_safe(rst_core), .sd_safe(rst_keep | self_refresh),
    .sd_addr_only(fn_sdram_sel), .fn(fn_b), .pins(pin_b));

  assign mem_addr   = pin_b.addr;
  assign mem_dout   = pin_b.dout;
  assign mem_oe_n   = pin_b.oe_n;
  assign mem_we_n   = pin_b.we_n;
  assign mem_bls_n  = pin_b.bls_n;
  assign mem_cs_n   = pin_b.cs_n;
  assign mem_dycs_n = pin_b.dycs_n;
  assign mem_ras_n  = pin_b.ras_n;
  assign mem_cas_n  = pin_b.cas_n;

  // R5: without a write strobe the retention bit holds outside power-on reset
  assert_keep_holds_R5: assert property (@(posedge clk) disable iff (por_s)
    (!keep_we && $past(!por_s)) |=> (keep_bit == $past(keep_bit)));
endmodule

// File: tb/test_mc_reset_steer.sv
module test_mc_reset_steer;
  localparam int DEF = 20;

  logic        clk = 1'b0;
  logic        por_in, warm_in, keep_we, keep_din, ivl_we, self_refresh, fn_sdram_sel;
  logic [7:0]  ivl_din;
  logic [23:0] fn_addr;
  logic [31:0] fn_dout;
  logic        fn_oe_n, fn_we_n, fn_ras_n, fn_cas_n;
  logic [3:0]  fn_bls_n, fn_cs_n, fn_dycs_n;
  logic        rst_core, rst_keep, keep_q, refresh_req;
  logic [23:0] mem_addr;
  logic [31:0] mem_dout;
  logic        mem_oe_n, mem_we_n, mem_ras_n, mem_cas_n;
  logic [3:0]  mem_bls_n, mem_cs_n, mem_dycs_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mc_reset_steer i_mc_reset_steer (
    .clk(clk), .por_in(por_in), .warm_in(warm_in), .keep_we(keep_we),
    .keep_din(keep_din), .ivl_we(ivl_we), .ivl_din(ivl_din),
    .self_refresh(self_refresh), .fn_sdram_sel(fn_sdram_sel),
    .fn_addr(fn_addr), .fn_dout(fn_dout), .fn_oe_n(fn_oe_n), .fn_we_n(fn_we_n),
    .fn_bls_n(fn_bls_n), .fn_cs_n(fn_cs_n), .fn_dycs_n(fn_dycs_n),
    .fn_ras_n(fn_ras_n), .fn_cas_n(fn_cas_n),
    .rst_core(rst_core), .rst_keep(rst_keep), .keep_q(keep_q),
    .refresh_req(refresh_req), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bls_n(mem_bls_n),
    .mem_cs_n(mem_cs_n), .mem_dycs_n(mem_dycs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_req(input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (refresh_req) begin n = i; break; end
    end
  endtask

  task automatic chk_static_safe(input string tag);
    check({tag, " addr"}, mem_addr, 0);
    check({tag, " dout"}, mem_dout, 0);
    check({tag, " oe/we/bls/cs"}, {mem_oe_n, mem_we_n, mem_bls_n, mem_cs_n}, 10'h3FF);
  endtask

  task automatic chk_sd_safe(input string tag);
    check({tag, " dycs/ras/cas"}, {mem_dycs_n, mem_ras_n, mem_cas_n}, 6'h3F);
  endtask

  task automatic set_fn();
    fn_addr = 24'hABCDEF; fn_dout = 32'h12345678; fn_oe_n = 0; fn_we_n = 0;
    fn_bls_n = 4'h0; fn_cs_n = 4'hE; fn_dycs_n = 4'hD; fn_ras_n = 0; fn_cas_n = 0;
  endtask

  // R1, R4, R7, R8: power-on reset state and release
  task automatic t_por();
    int n;
    @(negedge clk);
    por_in = 1'b1; #1;
    check("R1 por async rst_core", rst_core, 1);
    check("R1 por async rst_keep", rst_keep, 1);
    repeat (3) @(negedge clk);
    chk_static_safe("R7 por");
    chk_sd_safe("R8 por");
    check("R4 keep bit cleared", keep_q, 0);
    check("R1 no req in reset", refresh_req, 0);
    por_in = 1'b0;
    @(negedge clk);
    check("R1 still in reset after edge 1", rst_core, 1);
    @(negedge clk);
    check("R1 released after edge 2", {rst_core, rst_keep}, 0);
    repeat (DEF + 3 - 2) begin
      @(negedge clk);
      if (refresh_req) break;
    end
    check("R6 first req at IVL_DEF+3 after por", refresh_req, 1);
    wait_req(100, n);
  endtask

  // R10: functional pin pass-through and SDRAM address mask
  task automatic t_func();
    @(negedge clk);
    set_fn(); fn_sdram_sel = 0;
    @(negedge clk);
    check("R10 addr", mem_addr, 24'hABCDEF);
    check("R10 dout", mem_dout, 32'h12345678);
    check("R10 ctl", {mem_oe_n, mem_we_n, mem_bls_n, mem_cs_n}, {2'b00, 4'h0, 4'hE});
    check("R10 sd", {mem_dycs_n, mem_ras_n, mem_cas_n}, {4'hD, 2'b00});
    fn_sdram_sel = 1;
    @(negedge clk);
    check("R10 sdram addr mask", mem_addr, 24'h004DEF);
    fn_sdram_sel = 0;
  endtask

  // R6: programmed period and pulse width
  task automatic t_period();
    int n;
    @(negedge clk);
    ivl_we = 1; ivl_din = 8'd9;
    @(negedge clk);
    ivl_we = 0;
    wait_req(100, n);
    wait_req(100, n);
    check("R6 period ivl+1", n, 10);
    @(negedge clk);
    check("R6 single cycle pulse", refresh_req, 0);
    wait_req(100, n);
    check("R6 period repeat", n, 9);
  endtask

  // R2: warm reset with retention off clears everything
  task automatic t_warm_nokeep();
    int reqs = 0;
    int n;
    @(negedge clk);
    warm_in = 1; #1;
    check("R2 rst_core", rst_core, 1);
    check("R2 rst_keep", rst_keep, 1);
    repeat (30) begin
      @(negedge clk);
      if (refresh_req) reqs++;
    end
    check("R2 no req during warm reset", reqs, 0);
    chk_sd_safe("R8 warm nokeep");
    chk_static_safe("R7 warm nokeep");
    warm_in = 0;
    wait_req(100, n);
    check("R2 interval reset, first req", n, DEF + 3);
  endtask

  // R3, R5: warm reset with retention on keeps refresh alive
  task automatic t_warm_keep();
    int cyc = 0;
    int reqs = 0;
    int n;
    @(negedge clk);
    keep_we = 1; keep_din = 1; ivl_we = 1; ivl_din = 8'd9;
    @(negedge clk);
    keep_we = 0; keep_din = 0; ivl_we = 0;
    check("R5 keep bit written", keep_q, 1);
    @(negedge clk);
    check("R5 keep_din ignored without strobe", keep_q, 1);
    wait_req(100, n);
    wait_req(100, n);
    @(negedge clk);
    cyc = 1;
    warm_in = 1; #1;
    check("R3 rst_core high", rst_core, 1);
    check("R3 rst_keep low", rst_keep, 0);
    repeat (34) begin
      @(negedge clk);
      cyc++;
      if (refresh_req) begin
        check("R3 spacing during warm reset", cyc, 10);
        reqs++; cyc = 0;
      end
    end
    check("R3 req count during warm reset", reqs, 3);
    chk_static_safe("R7 warm keep");
    check("R3 sdram strobes follow fn", {mem_dycs_n, mem_ras_n, mem_cas_n}, {4'hD, 2'b00});
    check("R5 keep survives warm reset", keep_q, 1);
    warm_in = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cyc++;
      if (refresh_req) break;
    end
    check("R3 spacing across release", cyc, 10);
    check("R5 keep after warm release", keep_q, 1);
  endtask

  // R4: brown-out with retention on clears all
  task automatic t_brownout();
    int reqs = 0;
    int n;
    @(negedge clk);
    por_in = 1; #1;
    check("R4 rst_keep on brown-out", rst_keep, 1);
    repeat (25) begin
      @(negedge clk);
      if (refresh_req) reqs++;
    end
    check("R4 no req in brown-out", reqs, 0);
    chk_static_safe("R7 brown-out");
    chk_sd_safe("R8 brown-out");
    por_in = 0;
    wait_req(100, n);
    check("R4 interval reset, first req", n, DEF + 3);
    check("R4 keep bit cleared", keep_q, 0);
  endtask

  // R8, R9: self-refresh idles SDRAM strobes and suppresses requests
  task automatic t_selfref();
    int reqs = 0;
    @(negedge clk);
    self_refresh = 1;
    @(negedge clk);
    chk_sd_safe("R8 self-refresh");
    check("R10 static pins unaffected by self-refresh", mem_addr, 24'hABCDEF);
    repeat (30) begin
      @(negedge clk);
      if (refresh_req) reqs++;
    end
    check("R9 no req in self-refresh", reqs, 0);
    self_refresh = 0;
    @(negedge clk);
    check("R8 strobes released", {mem_dycs_n, mem_ras_n, mem_cas_n}, {4'hD, 2'b00});
  endtask

  initial begin
    por_in = 1; warm_in = 0; keep_we = 0; keep_din = 0; ivl_we = 0; ivl_din = 0;
    self_refresh = 0; fn_sdram_sel = 0;
    set_fn();
    t_por();
    t_func();
    t_period();
    t_warm_nokeep();
    t_warm_keep();
    t_brownout();
    t_selfref();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule